// File: doc/BRIEF.md
# Acquisition Trigger Controller

This block merges three trigger sources into one acquisition start pulse, which begins a capture on a data acquisition path. The sources are a software request, a cascade pulse from a neighbouring unit, and a hardware trigger pulse. Software requests and other control actions fire on the rising edge of a control level, not while the level is held. So a software trigger needs the request bit to fall and rise again before it fires a second time.

A hardware trigger is accepted only while the unit is armed. Arming happens on a rising edge of the arm level. After a hardware trigger is accepted, the unit either stays armed (automatic re-arm) or disarms and waits for the next arm edge. Each source keeps a sticky status flag, and so does the combined trigger. A freeze request comes either from a software freeze level or from an external request that a permit bit lets through. It produces a one-cycle freeze pulse for the circular buffers and latches its own sticky flag. One rising edge on the clear level clears every sticky flag. A counter records each accepted acquisition trigger.

All outputs are registered. An event on the inputs sampled at a clock edge appears on the outputs right after that same edge.

Top module: `acq_trig_ctrl`

## Requirements
- R1: A rising edge of `sw_trig_i` (0 in the previous cycle, 1 now) is a software trigger. Holding the level at 1 gives no further trigger. Status bit 0 records it.
- R2: A `casc_trig_i` pulse is a cascade trigger only while `casc_en_i` is 1. Otherwise it has no effect on any output. Status bit 1 records it.
- R3: A rising edge of `arm_i` sets the armed flag, status bit 3. A `hw_trig_i` pulse is accepted only while that flag is set. When the flag is clear the pulse is ignored: no trigger, no count, and status bit 2 stays unchanged. Status bit 2 records accepted hardware triggers.
- R4: When an accepted hardware trigger occurs with `auto_rearm_i` at 1, the armed flag stays set. With `auto_rearm_i` at 0, the flag clears.
- R5: Status bits 0, 1 and 2 are sticky. Each sets on its source's first trigger and holds until a clear.
- R6: `acq_trig_o` is high for exactly one cycle after any cycle with at least one accepted trigger. This holds even when several sources fire in that cycle. Status bit 4 is the sticky combined flag for the same condition.
- R7: A rising edge of `clr_i` clears status bits 0, 1, 2, 4 and 5, and leaves bit 3 alone. If a flag's set condition occurs in the same cycle as the clear, the set wins.
- R8: A freeze request is either a rising edge of `sw_freeze_i`, or `hw_freeze_req_i` while `hw_freeze_en_i` is 1. Each request gives a one-cycle `freeze_o` pulse and sets sticky status bit 5. A hardware request while `hw_freeze_en_i` is 0 is ignored. A freeze request never produces a trigger.
- R9: `trig_count_o` increases by one for each cycle with an accepted trigger. By default it wraps modulo 2^CNT_W. With CNT_SAT set, it stops at its maximum.
- R10: During and right after reset, all outputs are 0.
- R11: If an arm edge and an accepted hardware trigger fall in the same cycle with `auto_rearm_i` at 0, the unit ends up armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_trig_i | input | 1 | Software trigger request level |
| casc_en_i | input | 1 | Cascade trigger permit |
| casc_trig_i | input | 1 | Cascade trigger pulse |
| arm_i | input | 1 | Arm level, acts on its rising edge |
| auto_rearm_i | input | 1 | Keep armed after a hardware trigger |
| hw_trig_i | input | 1 | Hardware trigger pulse |
| clr_i | input | 1 | Status clear level, acts on its rising edge |
| sw_freeze_i | input | 1 | Software freeze level, acts on its rising edge |
| hw_freeze_en_i | input | 1 | Permit for external freeze requests |
| hw_freeze_req_i | input | 1 | External freeze request |
| acq_trig_o | output | 1 | One-cycle acquisition start pulse |
| freeze_o | output | 1 | One-cycle buffer freeze pulse |
| stat_o | output | 6 | Status: 0 sw, 1 cascade, 2 hw, 3 armed, 4 combined, 5 freeze |
| trig_count_o | output | CNT_W | Accepted trigger count |

## Verification
The trigger merge is driven with each source alone. It is also driven with several sources in the same cycle, which separates "one pulse per cycle" from "one pulse per source". Held request levels separate edge detection from level detection. Hardware pulses sent before arming, after a manual-mode fire and under automatic re-arm separate the three arming outcomes. A clear edge that coincides with a new trigger shows which side wins. A long stretch of random input levels is compared against the behavioural model on every cycle, to catch interactions the directed cases miss.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
   // status vector bit positions
   localparam int ST_SW    = 0;
   localparam int ST_CASC  = 1;
   localparam int ST_HW    = 2;
   localparam int ST_ARMED = 3;
   localparam int ST_ANY   = 4;
   localparam int ST_FRZ   = 5;
   localparam int ST_W     = 6;

   // edge-detected control levels
   localparam int CE_SW  = 0;
   localparam int CE_ARM = 1;
   localparam int CE_CLR = 2;
   localparam int CE_FRZ = 3;
   localparam int CE_W   = 4;

   // sticky flag bank slots
   localparam int SK_SW   = 0;
   localparam int SK_CASC = 1;
   localparam int SK_HW   = 2;
   localparam int SK_ANY  = 3;
   localparam int SK_FRZ  = 4;
   localparam int SK_W    = 5;

   typedef struct packed {
      logic hw;
      logic casc;
      logic sw;
   } trig_src_t;
endpackage

// File: rtl/atc_rise_det.sv
module atc_rise_det #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o
);
   if (W < 1) begin : g_bad_w
      $error("atc_rise_det: W must be at least 1");
   end

   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/atc_sticky.sv
module atc_sticky #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] flag_o
);
   if (N < 1) begin : g_bad_n
      $error("atc_sticky: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[i]) q <= 1'b1;   // set has priority over clear
         else if (clr_i)    q <= 1'b0;
      end
      assign flag_o[i] = q;
   end
endmodule

// File: rtl/atc_event_cnt.sv
module atc_event_cnt #(
   parameter int W   = 32,
   parameter bit SAT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   if (W < 2 || W > 64) begin : g_bad_w
      $error("atc_event_cnt: W must lie in 2..64");
   end

   logic [W-1:0] cnt_q;

   if (SAT) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                        cnt_q <= '0;
         else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)     cnt_q <= '0;
         else if (inc_i) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/atc_arm_ctl.sv
module atc_arm_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_rise_i,
   input  logic auto_rearm_i,
   input  logic hw_pulse_i,
   output logic armed_o,
   output logic hw_accept_o
);
   logic armed_q;

   assign hw_accept_o = hw_pulse_i & armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                          armed_q <= 1'b0;
      else if (arm_rise_i)                 armed_q <= 1'b1;   // arm wins over disarm
      else if (hw_accept_o && !auto_rearm_i) armed_q <= 1'b0;
   end

   assign armed_o = armed_q;
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
   import acq_trig_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter bit CNT_SAT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_trig_i,
   input  logic             casc_en_i,
   input  logic             casc_trig_i,
   input  logic             arm_i,
   input  logic             auto_rearm_i,
   input  logic             hw_trig_i,
   input  logic             clr_i,
   input  logic             sw_freeze_i,
   input  logic             hw_freeze_en_i,
   input  logic             hw_freeze_req_i,
   output logic             acq_trig_o,
   output logic             freeze_o,
   output logic [5:0]       stat_o,
   output logic [CNT_W-1:0] trig_count_o
);
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
      $error("acq_trig_ctrl: CNT_W must lie in 2..64");
   end
   if (ST_W != 6) begin : g_bad_st
      $error("acq_trig_ctrl: status width mismatch");
   end

   logic [CE_W-1:0] ctl_lvl, ctl_rise;
   logic [SK_W-1:0] sk_set, sk_flag;
   trig_src_t       src;
   logic            armed, hw_acc, any_ev, frz_ev;
   logic            trig_q, frz_q;

   always_comb begin
      ctl_lvl         = '0;
      ctl_lvl[CE_SW]  = sw_trig_i;
      ctl_lvl[CE_ARM] = arm_i;
      ctl_lvl[CE_CLR] = clr_i;
      ctl_lvl[CE_FRZ] = sw_freeze_i;
   end

   atc_rise_det #(.W(CE_W)) u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (ctl_lvl),
      .rise_o (ctl_rise)
   );

   atc_arm_ctl u_arm (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_rise_i   (ctl_rise[CE_ARM]),
      .auto_rearm_i (auto_rearm_i),
      .hw_pulse_i   (hw_trig_i),
      .armed_o      (armed),
      .hw_accept_o  (hw_acc)
   );

   always_comb begin
      src.sw   = ctl_rise[CE_SW];
      src.casc = casc_en_i & casc_trig_i;
      src.hw   = hw_acc;
      any_ev   = |src;
      frz_ev   = ctl_rise[CE_FRZ] | (hw_freeze_en_i & hw_freeze_req_i);

      sk_set          = '0;
      sk_set[SK_SW]   = src.sw;
      sk_set[SK_CASC] = src.casc;
      sk_set[SK_HW]   = src.hw;
      sk_set[SK_ANY]  = any_ev;
      sk_set[SK_FRZ]  = frz_ev;
   end

   atc_sticky #(.N(SK_W)) u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (sk_set),
      .clr_i  (ctl_rise[CE_CLR]),
      .flag_o (sk_flag)
   );

   atc_event_cnt #(.W(CNT_W), .SAT(CNT_SAT)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (any_ev),
      .cnt_o (trig_count_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         frz_q  <= 1'b0;
      end else begin
         trig_q <= any_ev;
         frz_q  <= frz_ev;
      end
   end

   always_comb begin
      stat_o           = '0;
      stat_o[ST_SW]    = sk_flag[SK_SW];
      stat_o[ST_CASC]  = sk_flag[SK_CASC];
      stat_o[ST_HW]    = sk_flag[SK_HW];
      stat_o[ST_ARMED] = armed;
      stat_o[ST_ANY]   = sk_flag[SK_ANY];
      stat_o[ST_FRZ]   = sk_flag[SK_FRZ];
   end

   assign acq_trig_o = trig_q;
   assign freeze_o   = frz_q;
endmodule

// File: rtl/acq_trig_ctrl_chk.sv
module acq_trig_ctrl_chk #(
   parameter int CNT_W   = 32,
   parameter bit CNT_SAT = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm_i,
   input logic             clr_i,
   input logic             acq_trig_o,
   input logic             freeze_o,
   input logic [5:0]       stat_o,
   input logic [CNT_W-1:0] trig_count_o
);
   // R6
   trig_sets_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acq_trig_o |-> stat_o[4]);
   // R6
   any_rise_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[4]) |-> acq_trig_o);
   // R8
   freeze_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_o |-> stat_o[5]);
   // R3
   armed_rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[3]) |-> $past(arm_i));
   // R4
   disarm_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_o[3]) |-> acq_trig_o);
   // R7
   sw_flag_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_o[0]) |-> $past(clr_i));
   // R7
   any_flag_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_o[4]) |-> $past(clr_i));
   // R9
   count_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acq_trig_o |-> $stable(trig_count_o));
   // R9
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_trig_o && !CNT_SAT) |-> trig_count_o == CNT_W'($past(trig_count_o) + 1'b1));
endmodule

bind acq_trig_ctrl acq_trig_ctrl_chk #(.CNT_W(CNT_W), .CNT_SAT(CNT_SAT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .arm_i        (arm_i),
   .clr_i        (clr_i),
   .acq_trig_o   (acq_trig_o),
   .freeze_o     (freeze_o),
   .stat_o       (stat_o),
   .trig_count_o (trig_count_o)
);

// File: tb/test_acq_trig_ctrl.sv
module test_acq_trig_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_trig_i = 0, casc_en_i = 0, casc_trig_i = 0, arm_i = 0;
   logic        auto_rearm_i = 0, hw_trig_i = 0, clr_i = 0, sw_freeze_i = 0;
   logic        hw_freeze_en_i = 0, hw_freeze_req_i = 0;
   logic        acq_trig_o, freeze_o;
   logic [5:0]  stat_o;
   logic [31:0] trig_count_o;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   acq_trig_ctrl i_acq_trig_ctrl (
      .clk(clk), .rst_n(rst_n), .sw_trig_i(sw_trig_i), .casc_en_i(casc_en_i),
      .casc_trig_i(casc_trig_i), .arm_i(arm_i), .auto_rearm_i(auto_rearm_i),
      .hw_trig_i(hw_trig_i), .clr_i(clr_i), .sw_freeze_i(sw_freeze_i),
      .hw_freeze_en_i(hw_freeze_en_i), .hw_freeze_req_i(hw_freeze_req_i),
      .acq_trig_o(acq_trig_o), .freeze_o(freeze_o), .stat_o(stat_o),
      .trig_count_o(trig_count_o)
   );

   // behavioural reference model
   bit m_sw_p, m_arm_p, m_clr_p, m_frz_p;
   bit m_armed, m_trig, m_frz;
   bit m_f_sw, m_f_casc, m_f_hw, m_f_any, m_f_frz;
   longint m_cnt;

   always @(posedge clk) begin
      bit e_sw, e_casc, e_hw, e_any, e_frz, e_clr, e_arm;
      if (!rst_n) begin
         {m_sw_p, m_arm_p, m_clr_p, m_frz_p} = '0;
         {m_armed, m_trig, m_frz} = '0;
         {m_f_sw, m_f_casc, m_f_hw, m_f_any, m_f_frz} = '0;
         m_cnt = 0;
      end else begin
         e_sw   = sw_trig_i && !m_sw_p;
         e_casc = casc_en_i && casc_trig_i;
         e_hw   = hw_trig_i && m_armed;
         e_any  = e_sw || e_casc || e_hw;
         e_frz  = (sw_freeze_i && !m_frz_p) || (hw_freeze_en_i && hw_freeze_req_i);
         e_clr  = clr_i && !m_clr_p;
         e_arm  = arm_i && !m_arm_p;
         if (e_clr) {m_f_sw, m_f_casc, m_f_hw, m_f_any, m_f_frz} = '0;
         if (e_sw)   m_f_sw = 1;
         if (e_casc) m_f_casc = 1;
         if (e_hw)   m_f_hw = 1;
         if (e_any)  m_f_any = 1;
         if (e_frz)  m_f_frz = 1;
         if (e_hw && !auto_rearm_i) m_armed = 0;
         if (e_arm) m_armed = 1;
         if (e_any) m_cnt = (m_cnt + 1) % 64'h1_0000_0000;
         m_trig = e_any;
         m_frz  = e_frz;
         m_sw_p = sw_trig_i; m_arm_p = arm_i; m_clr_p = clr_i; m_frz_p = sw_freeze_i;
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) if (rst_n && !done) begin
      chk("R6", "acq_trig_o", acq_trig_o, m_trig);
      chk("R8", "freeze_o", freeze_o, m_frz);
      chk("R1", "stat sw", stat_o[0], m_f_sw);
      chk("R2", "stat casc", stat_o[1], m_f_casc);
      chk("R3", "stat hw", stat_o[2], m_f_hw);
      chk("R4", "stat armed", stat_o[3], m_armed);
      chk("R6", "stat any", stat_o[4], m_f_any);
      chk("R8", "stat freeze", stat_o[5], m_f_frz);
      chk("R9", "count", trig_count_o, m_cnt);
   end

   task automatic cyc(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #800000;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      cyc(3);
      // R10: reset state
      chk("R10", "trig in reset", acq_trig_o, 0);
      chk("R10", "stat in reset", stat_o, 0);
      chk("R10", "count in reset", trig_count_o, 0);
      rst_n = 1;
      cyc(1);
      chk("R10", "stat after reset", stat_o, 0);
      chk("R10", "freeze after reset", freeze_o, 0);

      // R1: edge, then held level
      sw_trig_i = 1; cyc(1);
      chk("R1", "sw edge trig", acq_trig_o, 1);
      chk("R5", "sw sticky", stat_o[0], 1);
      cyc(2);
      chk("R1", "held level no trig", acq_trig_o, 0);
      chk("R1", "held level count", trig_count_o, 1);
      sw_trig_i = 0; cyc(1);
      chk("R5", "sw sticky held", stat_o[0], 1);

      // R2: cascade gating
      casc_trig_i = 1; cyc(1); casc_trig_i = 0;
      chk("R2", "casc disabled trig", acq_trig_o, 0);
      chk("R2", "casc disabled stat", stat_o[1], 0);
      casc_en_i = 1; casc_trig_i = 1; cyc(1); casc_trig_i = 0;
      chk("R2", "casc enabled trig", acq_trig_o, 1);
      chk("R9", "count after casc", trig_count_o, 2);

      // R3: unarmed hw ignored, then arm
      hw_trig_i = 1; cyc(1); hw_trig_i = 0;
      chk("R3", "unarmed hw trig", acq_trig_o, 0);
      chk("R3", "unarmed hw count", trig_count_o, 2);
      chk("R3", "unarmed hw stat", stat_o[2], 0);
      arm_i = 1; cyc(1); arm_i = 0;
      chk("R3", "armed flag", stat_o[3], 1);
      hw_trig_i = 1; cyc(1); hw_trig_i = 0;
      chk("R3", "armed hw trig", acq_trig_o, 1);
      chk("R4", "manual disarm", stat_o[3], 0);
      hw_trig_i = 1; cyc(1); hw_trig_i = 0;
      chk("R3", "after disarm count", trig_count_o, 3);

      // R4: auto re-arm
      auto_rearm_i = 1; arm_i = 1; cyc(1); arm_i = 0;
      hw_trig_i = 1; cyc(2); hw_trig_i = 0;
      chk("R4", "auto stays armed", stat_o[3], 1);
      chk("R9", "two auto hits", trig_count_o, 5);

      // R7: clear and set-wins
      clr_i = 1; cyc(1);
      chk("R7", "clear flags", stat_o & 6'b110111, 0);
      chk("R7", "clear keeps armed", stat_o[3], 1);
      clr_i = 0; cyc(1);
      clr_i = 1; sw_trig_i = 1; cyc(1); clr_i = 0; sw_trig_i = 0;
      chk("R7", "set wins sw", stat_o[0], 1);
      chk("R7", "set wins any", stat_o[4], 1);
      chk("R7", "casc cleared", stat_o[1], 0);

      // R6: simultaneous sources give one count
      sw_trig_i = 1; casc_trig_i = 1; hw_trig_i = 1; cyc(1);
      sw_trig_i = 0; casc_trig_i = 0; hw_trig_i = 0;
      chk("R6", "multi source pulse", acq_trig_o, 1);
      chk("R6", "multi source count", trig_count_o, 7);
      cyc(1);
      chk("R6", "pulse one cycle", acq_trig_o, 0);

      // R8: freeze paths
      hw_freeze_req_i = 1; cyc(1);
      chk("R8", "masked freeze", freeze_o, 0);
      chk("R8", "masked freeze stat", stat_o[5], 0);
      hw_freeze_en_i = 1; cyc(1); hw_freeze_req_i = 0;
      chk("R8", "hw freeze", freeze_o, 1);
      chk("R8", "freeze no trig", acq_trig_o, 0);
      chk("R8", "freeze stat", stat_o[5], 1);
      sw_freeze_i = 1; cyc(1);
      chk("R8", "sw freeze", freeze_o, 1);
      cyc(1);
      chk("R8", "sw freeze held", freeze_o, 0);
      sw_freeze_i = 0;

      // R11: arm edge with accepted hw fire, manual mode
      auto_rearm_i = 0; hw_trig_i = 1; arm_i = 1; cyc(1); hw_trig_i = 0; arm_i = 0;
      chk("R11", "arm beats disarm", stat_o[3], 1);
      chk("R11", "trig accepted", acq_trig_o, 1);

      // random stretch checked by the model
      for (int i = 0; i < 4000; i++) begin
         sw_trig_i       = $urandom_range(0, 3) == 0;
         casc_en_i       = $urandom_range(0, 1);
         casc_trig_i     = $urandom_range(0, 7) == 0;
         arm_i           = $urandom_range(0, 5) == 0;
         auto_rearm_i    = $urandom_range(0, 1);
         hw_trig_i       = $urandom_range(0, 3) == 0;
         clr_i           = $urandom_range(0, 9) == 0;
         sw_freeze_i     = $urandom_range(0, 7) == 0;
         hw_freeze_en_i  = $urandom_range(0, 1);
         hw_freeze_req_i = $urandom_range(0, 7) == 0;
         cyc(1);
      end
      cyc(2);
      finish_run();
   end
endmodule